// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the address-latch strobe of a microcontroller bus and decides when the attached memory and logic may sleep. When enabled, a small idle counter starts as soon as the strobe stops toggling. If the strobe stays quiet for fifteen clock periods, the block raises a power-down flag. Three things bring the system back to normal operation at once: any new strobe transition, the active-low chip select going low, or reset.

While power-down is asserted, the block does two things. It raises a bus-block output that isolates the microcontroller address/data bus from all memory and logic. It also drives a per-port-class mode code that states how each group of pins behaves. Two byte-wide configuration registers hold the enable bit and a set of mask bits. The mask bits keep selected microcontroller control signals, and the shared clock, out of the programmable logic. Masking the clock only gates the copy that goes to the logic. The idle counter keeps running on the real clock.

Top module: `busidle_pd_ctrl`

## Requirements
- R1: While `rst` is high and right after it falls, `pd_o` and `bus_block_o` are 0, `port_mode_o` is 0, both configuration registers read 0, `arr_clk_en_o` is 1 and `arr_ctl_o` equals `ctl_in`.
- R2: Both rising and falling transitions of `strobe_in`, sampled on `clk`, clear the idle count. Such a transition also drops `pd_o` at the clock edge that samples it.
- R3: When enabled, and with `csel_n` high and `strobe_in` steady, `pd_o` rises at the 15th rising clock edge after the edge that cleared the count. It then stays high while the bus stays idle.
- R4: When the enable bit (register 0, bit 1) is 0, `pd_o` never rises and the count is held at zero. A write that clears the bit while `pd_o` is high drops `pd_o` one clock after the write edge. After re-enabling, a full 15-edge idle period is needed again.
- R5: Whenever `csel_n` is sampled low, the count is cleared and `pd_o` is 0 after that edge. Counting restarts from zero once `csel_n` returns high.
- R6: Raising `rst` while powered down drops `pd_o` at once. It also clears both registers, which leaves the unit disabled.
- R7: `bus_block_o` equals `pd_o` at all times.
- R8: `port_mode_o` is 0 when not powered down. During power-down it is 8'hE5. Bits [1:0] (microcontroller I/O) and [3:2] (logic outputs) are 01 = hold. Bits [5:4] (address outputs) are 10 = undefined. Bits [7:6] (peripheral I/O) are 11 = tri-state.
- R9: Register 0 (`reg_addr`=0) keeps only bits 1, 4 and 5, so writing 8'hFF reads back 8'h32. Register 2 keeps only bits 2 to 6, so writing 8'hFF reads back 8'h7C. Addresses 1 and 3 always read 0. Reads are combinational on `reg_rdata`.
- R10: `arr_ctl_o` is `ctl_in` with blocked bits forced to 0. Register 0 bit 5 blocks control bit 0. Register 2 bit k (k = 2 to 6) blocks control bit k-1.
- R11: Register 0 bit 4 drives `arr_clk_en_o` to 0. Idle timing and power-down entry are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that times the idle period |
| rst | input | 1 | Asynchronous active-high reset; also a wake event |
| strobe_in | input | 1 | Microcontroller address-latch strobe |
| csel_n | input | 1 | Active-low chip select; low wakes the block |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ctl_in | input | 6 | Microcontroller control signals heading to the logic |
| pd_o | output | 1 | Power-down flag |
| bus_block_o | output | 1 | Isolates the microcontroller bus from memory and logic |
| arr_clk_en_o | output | 1 | Clock enable for the logic's copy of the clock |
| arr_ctl_o | output | 6 | Control signals after masking |
| port_mode_o | output | 8 | Per-port-class power-down mode, two bits per class |

## Verification
The bench sets the idle period so that the 14th quiet edge must leave `pd_o` low and the 15th must raise it. A counter that is off by one in either direction fails one of those two samples. It wakes the block with a rising strobe edge, with a falling strobe edge, with a chip-select pulse and with reset. A design that reacted to only one edge polarity, or failed to restart the count after chip select, would then enter power-down early or stay in it. It also clears the enable bit while powered down and re-enables it. A design that kept a stale count would then sleep too soon. Finally, it masks the clock and shows that power-down entry still happens on time. Writes of all-ones expose mask bits stored at the wrong positions.

// File: rtl/busidle_pkg.sv
package busidle_pkg;

    // Two-bit behaviour code for a class of pins during power-down
    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_HOLD   = 2'b01,
        PM_UNDEF  = 2'b10,
        PM_HIZ    = 2'b11
    } port_mode_e;

    // Port class slots inside the packed mode vector
    localparam int unsigned CLS_MCU_IO    = 0;
    localparam int unsigned CLS_LOGIC_OUT = 1;
    localparam int unsigned CLS_ADDR_OUT  = 2;
    localparam int unsigned CLS_PERIPH    = 3;
    localparam int unsigned N_PORT_CLASS  = 4;

    function automatic port_mode_e class_sleep_mode(input int unsigned idx);
        case (idx)
            CLS_MCU_IO:    return PM_HOLD;
            CLS_LOGIC_OUT: return PM_HOLD;
            CLS_ADDR_OUT:  return PM_UNDEF;
            CLS_PERIPH:    return PM_HIZ;
            default:       return PM_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/bip_idle_timer.sv
module bip_idle_timer #(
    parameter int unsigned IDLE_LIMIT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic strobe,
    input  logic csel_n,
    output logic pd
);
    localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

    typedef struct packed {
        logic             strobe;
        logic [CNT_W-1:0] cnt;
        logic             pd;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic activity;
    logic wake;

    always_comb begin
        tmr_d        = tmr_q;
        tmr_d.strobe = strobe;
        activity     = strobe ^ tmr_q.strobe;
        wake         = activity | ~csel_n;
        if (!en || wake) begin
            tmr_d.cnt = '0;
            tmr_d.pd  = 1'b0;
        end else begin
            if (tmr_q.cnt != LIMIT) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
            tmr_d.pd = (tmr_d.cnt == LIMIT);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign pd = tmr_q.pd;

endmodule

// File: rtl/bip_cfg_regs.sv
module bip_cfg_regs #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTL_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic              clk_blk,
    output logic [CTL_W-1:0]  ctl_blk
);
    localparam int unsigned EN_BIT     = 1;
    localparam int unsigned CLKBLK_BIT = 4;
    localparam int unsigned CTL0_BIT   = 5;
    localparam int unsigned CTLHI_LSB  = 2;
    localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CFG2 = ADDR_W'(2);
    localparam logic [DATA_W-1:0] WMASK0 =
        DATA_W'((1 << EN_BIT) | (1 << CLKBLK_BIT) | (1 << CTL0_BIT));
    localparam logic [DATA_W-1:0] WMASK2 =
        DATA_W'(((1 << (CTL_W - 1)) - 1) << CTLHI_LSB);

    typedef struct packed {
        logic [DATA_W-1:0] cfg0;
        logic [DATA_W-1:0] cfg2;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (addr)
                A_CFG0:  regs_d.cfg0 = wdata & WMASK0;
                A_CFG2:  regs_d.cfg2 = wdata & WMASK2;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            A_CFG0:  rdata = regs_q.cfg0;
            A_CFG2:  rdata = regs_q.cfg2;
            default: rdata = '0;
        endcase
    end

    assign en         = regs_q.cfg0[EN_BIT];
    assign clk_blk    = regs_q.cfg0[CLKBLK_BIT];
    assign ctl_blk[0] = regs_q.cfg0[CTL0_BIT];

    for (genvar g = 1; g < CTL_W; g++) begin : g_hi_mask
        assign ctl_blk[g] = regs_q.cfg2[CTLHI_LSB + g - 1];
    end

endmodule

// File: rtl/bip_port_gate.sv
module bip_port_gate
    import busidle_pkg::*;
#(
    parameter int unsigned CTL_W   = 6,
    parameter int unsigned N_CLASS = N_PORT_CLASS
) (
    input  logic                 pd,
    input  logic                 clk_blk,
    input  logic [CTL_W-1:0]     ctl_blk,
    input  logic [CTL_W-1:0]     ctl_in,
    output logic                 bus_block,
    output logic                 arr_clk_en,
    output logic [CTL_W-1:0]     arr_ctl,
    output logic [2*N_CLASS-1:0] port_mode
);
    localparam int unsigned MODE_W = 2;

    assign bus_block  = pd;
    assign arr_clk_en = ~clk_blk;
    assign arr_ctl    = ctl_in & ~ctl_blk;

    for (genvar g = 0; g < N_CLASS; g++) begin : g_class
        localparam port_mode_e SLEEP_MODE = class_sleep_mode(g);
        assign port_mode[g*MODE_W +: MODE_W] = pd ? SLEEP_MODE : PM_NORMAL;
    end

endmodule

// File: rtl/busidle_pd_ctrl.sv
module busidle_pd_ctrl
    import busidle_pkg::*;
#(
    parameter int unsigned IDLE_LIMIT = 15,
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CTL_W      = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      strobe_in,
    input  logic                      csel_n,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    input  logic [CTL_W-1:0]          ctl_in,
    output logic                      pd_o,
    output logic                      bus_block_o,
    output logic                      arr_clk_en_o,
    output logic [CTL_W-1:0]          arr_ctl_o,
    output logic [2*N_PORT_CLASS-1:0] port_mode_o
);
    logic             en;
    logic             clk_blk;
    logic [CTL_W-1:0] ctl_blk;

    bip_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CTL_W  (CTL_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .en      (en),
        .clk_blk (clk_blk),
        .ctl_blk (ctl_blk)
    );

    // The timer runs on the raw clock; clock masking only reaches the logic copy
    bip_idle_timer #(
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .strobe (strobe_in),
        .csel_n (csel_n),
        .pd     (pd_o)
    );

    bip_port_gate #(
        .CTL_W   (CTL_W),
        .N_CLASS (N_PORT_CLASS)
    ) u_gate (
        .pd         (pd_o),
        .clk_blk    (clk_blk),
        .ctl_blk    (ctl_blk),
        .ctl_in     (ctl_in),
        .bus_block  (bus_block_o),
        .arr_clk_en (arr_clk_en_o),
        .arr_ctl    (arr_ctl_o),
        .port_mode  (port_mode_o)
    );

endmodule

// File: rtl/busidle_pd_chk.sv
module busidle_pd_chk #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTL_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_in,
    input logic              csel_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [CTL_W-1:0]  ctl_in,
    input logic              pd_o,
    input logic              bus_block_o,
    input logic [CTL_W-1:0]  arr_ctl_o,
    input logic [7:0]        port_mode_o
);
    // R2: a strobe transition forces power-down off after the sampling edge
    a_r2_edge_wakes: assert property (@(posedge clk) disable iff (rst)
        (strobe_in != $past(strobe_in)) |=> !pd_o);

    // R5: chip select low forces power-down off
    a_r5_csel_wakes: assert property (@(posedge clk) disable iff (rst)
        !csel_n |=> !pd_o);

    // R4: clearing the enable bit drops power-down one clock after the write edge
    a_r4_disable_drops: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(0) && !reg_wdata[1]) |=> ##1 !pd_o);

    // R7: bus isolation follows the power-down flag
    a_r7_bus_follows_pd: assert property (@(posedge clk) disable iff (rst)
        bus_block_o == pd_o);

    // R8: port class codes
    a_r8_sleep_modes: assert property (@(posedge clk) disable iff (rst)
        pd_o |-> port_mode_o == 8'hE5);
    a_r8_awake_modes: assert property (@(posedge clk) disable iff (rst)
        !pd_o |-> port_mode_o == 8'h00);

    // R10: masking can only clear control bits, never set them
    a_r10_mask_only_clears: assert property (@(posedge clk) disable iff (rst)
        (arr_ctl_o & ~ctl_in) == '0);

    // R3: power-down never starts during a cycle where chip select was active
    a_r3_rise_needs_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_o) |-> $past(csel_n));

endmodule

bind busidle_pd_ctrl busidle_pd_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTL_W  (CTL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .strobe_in   (strobe_in),
    .csel_n      (csel_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .ctl_in      (ctl_in),
    .pd_o        (pd_o),
    .bus_block_o (bus_block_o),
    .arr_ctl_o   (arr_ctl_o),
    .port_mode_o (port_mode_o)
);

// File: tb/tb_busidle_pd_ctrl.sv
module tb_busidle_pd_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       strobe_in;
    logic       csel_n;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [5:0] ctl_in;
    logic       pd_o;
    logic       bus_block_o;
    logic       arr_clk_en_o;
    logic [5:0] arr_ctl_o;
    logic [7:0] port_mode_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    busidle_pd_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .strobe_in    (strobe_in),
        .csel_n       (csel_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ctl_in       (ctl_in),
        .pd_o         (pd_o),
        .bus_block_o  (bus_block_o),
        .arr_clk_en_o (arr_clk_en_o),
        .arr_ctl_o    (arr_ctl_o),
        .port_mode_o  (port_mode_o)
    );

    always #5 clk = ~clk;

    // Row: {strobe, csel_n, cycles[7:0], expected pd}
    localparam logic [10:0] VECS [0:14] = '{
        {1'b1, 1'b1, 8'd1,  1'b0},   // edge clears count
        {1'b1, 1'b1, 8'd14, 1'b0},   // 14 quiet edges: not yet
        {1'b1, 1'b1, 8'd1,  1'b1},   // 15th: power-down
        {1'b1, 1'b1, 8'd5,  1'b1},   // stays asleep
        {1'b0, 1'b1, 8'd1,  1'b0},   // falling edge wakes
        {1'b0, 1'b1, 8'd15, 1'b1},
        {1'b0, 1'b0, 8'd1,  1'b0},   // chip select wakes
        {1'b0, 1'b0, 8'd20, 1'b0},   // held awake
        {1'b0, 1'b1, 8'd14, 1'b0},   // restart from zero
        {1'b0, 1'b1, 8'd1,  1'b1},
        {1'b1, 1'b1, 8'd1,  1'b0},   // rising edge wakes
        {1'b1, 1'b1, 8'd10, 1'b0},
        {1'b0, 1'b1, 8'd1,  1'b0},   // edge mid-count clears
        {1'b0, 1'b1, 8'd14, 1'b0},
        {1'b0, 1'b1, 8'd1,  1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1 chk(req, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic step(input string req, input logic s, input logic c,
                        input int n, input logic exp);
        @(negedge clk);
        strobe_in = s; csel_n = c;
        repeat (n) @(posedge clk);
        #1;
        chk(req, 32'(pd_o), 32'(exp));
        chk("R7", 32'(bus_block_o), 32'(exp));
        chk("R8", 32'(port_mode_o), exp ? 32'hE5 : 32'h00);
    endtask

    function automatic string row_req(input int i);
        if (i == 4 || i == 10 || i == 12) return "R2";
        if (i == 6 || i == 7 || i == 8)   return "R5";
        return "R3";
    endfunction

    initial begin
        rst = 1'b1; strobe_in = 1'b0; csel_n = 1'b1; reg_we = 1'b0;
        reg_addr = '0; reg_wdata = '0; ctl_in = 6'h3F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", 32'(pd_o), 0);
        chk("R1", 32'(bus_block_o), 0);
        chk("R1", 32'(port_mode_o), 0);
        chk("R1", 32'(arr_clk_en_o), 1);
        chk("R1", 32'(arr_ctl_o), 32'h3F);
        rd("R1", 2'd0, 8'h00);
        rd("R1", 2'd2, 8'h00);

        // R4 disabled: no power-down however long the bus idles
        step("R4", 1'b0, 1'b1, 30, 1'b0);

        wr(2'd0, 8'h02);
        for (int i = 0; i < 15; i++) begin
            step(row_req(i), VECS[i][10], VECS[i][9], int'(VECS[i][8:1]), VECS[i][0]);
        end

        // R4 clear enable while asleep
        wr(2'd0, 8'h00);
        chk("R4", 32'(pd_o), 1);
        step("R4", 1'b0, 1'b1, 1, 1'b0);
        step("R4", 1'b0, 1'b1, 20, 1'b0);
        wr(2'd0, 8'h02);
        step("R4", 1'b0, 1'b1, 14, 1'b0);
        step("R4", 1'b0, 1'b1, 1, 1'b1);

        // R6 reset wakes and clears
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk("R6", 32'(pd_o), 0);
        rd("R6", 2'd0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        step("R6", 1'b0, 1'b1, 20, 1'b0);

        // R9 writable bits and unused addresses
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'hFF);
        @(negedge clk);
        rd("R9", 2'd0, 8'h32);
        rd("R9", 2'd2, 8'h7C);
        rd("R9", 2'd1, 8'h00);
        rd("R9", 2'd3, 8'h00);

        // R10 full and partial masking
        chk("R10", 32'(arr_ctl_o), 32'h00);
        chk("R11", 32'(arr_clk_en_o), 0);
        wr(2'd2, 8'h14);
        #1 chk("R10", 32'(arr_ctl_o), 32'h34);
        ctl_in = 6'h2A;
        #1 chk("R10", 32'(arr_ctl_o), 32'h20);

        // R11 idle timing unchanged with the clock masked
        step("R11", 1'b1, 1'b1, 1, 1'b0);
        step("R11", 1'b1, 1'b1, 14, 1'b0);
        step("R11", 1'b1, 1'b1, 1, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule